// File: doc/BRIEF.md
# Paged RAM banking controller

This block sits between the CPU address bus and a DRAM array made of a 64K base RAM plus extra 64K expansion pages. It splits the CPU address space into four 16K windows. For each CPU memory cycle it works out which physical 16K bank the access reaches, whether that bank is in base RAM or in an expansion page, and which page that is. It also decides which row strobe (base or expansion) the master strobe is passed to. Video fetches are never remapped and always go to base RAM at the bank given by their own top address bits.

The mapping comes from a write-only register that the CPU loads through an I/O write. The I/O port is shared with another device, so the block loads only writes whose data carries a fixed pattern in its two top bits. Bits 2..0 of the written byte choose one of eight window maps. Bits 5..3 choose the expansion page. An external RAM-disable input lets an add-on card take over a CPU access. A strobe already running on the expansion array is held until the master strobe ends, so a late disable cannot cut it short.

Top module: `ram_bank_ctl`

## Requirements
- R1: The register loads only when `io_wr_en` is high, `cpu_addr[15]` is 0 and `cpu_wdata[7:6]` is 2'b11. Any other write leaves the mapping unchanged.
- R2: `cpu_addr[14]` is not decoded for the register write, so port addresses with that bit at 0 or at 1 both load it.
- R3: While `rst_n` is low, the register holds mode 0 and page 0, and no strobe is held.
- R4: In mode 0, CPU windows 0..3 (`cpu_addr[15:14]`) go to base banks 0..3 with `ext_sel`=0.
- R5: In mode 1, window 3 goes to expansion bank 3. Windows 0..2 go to base banks 0..2.
- R6: In mode 2, every window w goes to expansion bank w.
- R7: In mode 3, window 1 goes to base bank 3 and window 3 goes to expansion bank 3. Windows 0 and 2 go to base banks 0 and 2.
- R8: In modes 4..7 (`cpu_wdata[2]`=1), window 1 goes to expansion bank `cpu_wdata[1:0]`. Every other window w goes to base bank w.
- R9: `page` always shows the stored page, taken from `cpu_wdata[5:3]`. When parameter EXPANDED is 0 it is stored as 0.
- R10: When `cpu_mem` is 0 (video cycle), `ext_sel` is 0 and `phys_bank` equals `cpu_addr[15:14]`.
- R11: A CPU cycle with `ram_disable` high starts no strobe. Both `base_strobe` and `ext_strobe` stay low unless an expansion strobe is already held.
- R12: Once `ext_strobe` is high it stays high for as long as `ras_req` stays high, whatever `ram_disable`, `cpu_mem` or the address do. While it is held, `base_strobe` stays low.
- R13: `phys_addr_lo` equals `cpu_addr[13:0]` in every cycle.
- R14: The new mapping is loaded on the clock edge that ends the qualifying write. It takes effect from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU or video address |
| cpu_wdata | input | 8 | CPU write data |
| io_wr_en | input | 1 | I/O write cycle qualifier |
| cpu_mem | input | 1 | 1 = CPU memory cycle, 0 = video fetch |
| ras_req | input | 1 | Master row strobe request |
| ram_disable | input | 1 | External RAM-disable |
| phys_bank | output | 2 | Physical bank (DRAM address bits 15..14) |
| ext_sel | output | 1 | 1 = expansion RAM selected |
| page | output | 3 | Expansion page number |
| phys_addr_lo | output | 14 | Address bits 13..0 passed through |
| base_strobe | output | 1 | Row strobe to base array |
| ext_strobe | output | 1 | Row strobe to expansion array |

## Verification
The bank, select, page and both strobes are combinational from the inputs and two registers. In a cycle without a write they are due within the same cycle. A register write shows on these outputs one clock edge later, and a held expansion strobe also depends on the value at the previous edge. The bench drives inputs just after the falling edge and compares all outputs one nanosecond before the next rising edge. Its model updates the stored mapping and the hold flag only at that rising edge, so a write is checked in the cycle after it and never during it.

// File: rtl/ram_bank_pkg.sv
package ram_bank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int WIN_W  = 2;
  localparam int MODE_W = 3;
  localparam int PAGE_W = 3;
  localparam int LO_W   = ADDR_W - WIN_W;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [PAGE_W-1:0] page;
  } map_cfg_t;

  typedef struct packed {
    logic             ext;
    logic [WIN_W-1:0] bank;
  } win_map_t;

  // True when an I/O write targets the mapping register.
  function automatic logic is_map_write(input logic wr, input logic a15,
                                        input logic [DATA_W-1:0] d);
    return wr && !a15 && (d[DATA_W-1:DATA_W-2] == 2'b11);
  endfunction

  // Window-to-bank translation for one CPU window.
  function automatic win_map_t map_window(input logic [MODE_W-1:0] mode,
                                          input logic [WIN_W-1:0] win);
    win_map_t r;
    r.ext  = 1'b0;
    r.bank = win;
    if (mode[2]) begin
      if (win == 2'd1) begin
        r.ext  = 1'b1;
        r.bank = mode[1:0];
      end
    end else begin
      case (mode[1:0])
        2'd1: if (win == 2'd3) r.ext = 1'b1;
        2'd2: r.ext = 1'b1;
        2'd3: begin
          if (win == 2'd1) r.bank = 2'd3;
          if (win == 2'd3) r.ext  = 1'b1;
        end
        default: ;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/bank_map_reg.sv
module bank_map_reg
  import ram_bank_pkg::*;
#(
  parameter bit EXPANDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_en,
  input  logic              port_a15,
  input  logic [DATA_W-1:0] wdata,
  output map_cfg_t          cfg,
  output logic              load_evt
);
  map_cfg_t cfg_q;

  assign load_evt = is_map_write(io_wr_en, port_a15, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load_evt) begin
      cfg_q.mode <= wdata[MODE_W-1:0];
      if (EXPANDED) cfg_q.page <= wdata[MODE_W+PAGE_W-1:MODE_W];
      else          cfg_q.page <= '0;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/bank_window_map.sv
module bank_window_map
  import ram_bank_pkg::*;
(
  input  map_cfg_t          cfg,
  input  logic              cpu_mem,
  input  logic [WIN_W-1:0]  win,
  output logic [WIN_W-1:0]  bank,
  output logic              ext_sel,
  output logic [PAGE_W-1:0] page
);
  win_map_t cpu_map;

  always_comb begin
    cpu_map = map_window(cfg.mode, win);
    if (cpu_mem) begin
      bank    = cpu_map.bank;
      ext_sel = cpu_map.ext;
    end else begin
      bank    = win;
      ext_sel = 1'b0;
    end
  end

  assign page = cfg.page;
endmodule

// File: rtl/bank_strobe_gate.sv
module bank_strobe_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_req,
  input  logic cpu_mem,
  input  logic ram_disable,
  input  logic ext_sel,
  output logic base_strobe,
  output logic ext_strobe,
  output logic ext_hold,
  output logic ext_start
);
  logic hold_q;

  assign ext_start   = ras_req && cpu_mem && !ram_disable && ext_sel;
  assign ext_strobe  = ras_req && (hold_q || ext_start);
  assign base_strobe = ras_req && !hold_q &&
                       (!cpu_mem || (!ram_disable && !ext_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= ext_strobe;
  end

  assign ext_hold = hold_q;
endmodule

// File: rtl/ram_bank_ctl.sv
module ram_bank_ctl
  import ram_bank_pkg::*;
#(
  parameter bit EXPANDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_wr_en,
  input  logic              cpu_mem,
  input  logic              ras_req,
  input  logic              ram_disable,
  output logic [WIN_W-1:0]  phys_bank,
  output logic              ext_sel,
  output logic [PAGE_W-1:0] page,
  output logic [LO_W-1:0]   phys_addr_lo,
  output logic              base_strobe,
  output logic              ext_strobe
);
  map_cfg_t          cfg;
  logic              load_evt;
  logic              ext_hold;
  logic              ext_start;
  logic [MODE_W-1:0] cfg_mode;
  logic [PAGE_W-1:0] cfg_page;

  bank_map_reg #(.EXPANDED(EXPANDED)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr_en (io_wr_en),
    .port_a15 (cpu_addr[ADDR_W-1]),
    .wdata    (cpu_wdata),
    .cfg      (cfg),
    .load_evt (load_evt)
  );

  bank_window_map u_map (
    .cfg     (cfg),
    .cpu_mem (cpu_mem),
    .win     (cpu_addr[ADDR_W-1:LO_W]),
    .bank    (phys_bank),
    .ext_sel (ext_sel),
    .page    (page)
  );

  bank_strobe_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_req     (ras_req),
    .cpu_mem     (cpu_mem),
    .ram_disable (ram_disable),
    .ext_sel     (ext_sel),
    .base_strobe (base_strobe),
    .ext_strobe  (ext_strobe),
    .ext_hold    (ext_hold),
    .ext_start   (ext_start)
  );

  assign cfg_mode     = cfg.mode;
  assign cfg_page     = cfg.page;
  assign phys_addr_lo = cpu_addr[LO_W-1:0];
endmodule

// File: rtl/ram_bank_ctl_chk.sv
module ram_bank_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        io_wr_en,
  input logic        cpu_mem,
  input logic        ras_req,
  input logic        ram_disable,
  input logic [1:0]  phys_bank,
  input logic        ext_sel,
  input logic        base_strobe,
  input logic        ext_strobe,
  input logic [2:0]  cfg_mode,
  input logic [2:0]  cfg_page,
  input logic        ext_hold
);
  logic qual_wr;
  assign qual_wr = io_wr_en && !cpu_addr[15] && (cpu_wdata[7:6] == 2'b11);

  p_load_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qual_wr |=> cfg_mode == $past(cpu_wdata[2:0]));

  p_ignore_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_wr |=> ($stable(cfg_mode) && $stable(cfg_page)));

  p_video_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mem |-> (!ext_sel && phys_bank == cpu_addr[15:14]));

  p_disable_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_req && cpu_mem && ram_disable && !ext_hold) |-> !(base_strobe || ext_strobe));

  p_ext_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_strobe && ras_req) |=> (!ras_req || ext_strobe));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_strobe && ext_strobe));
endmodule

bind ram_bank_ctl ram_bank_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .io_wr_en    (io_wr_en),
  .cpu_mem     (cpu_mem),
  .ras_req     (ras_req),
  .ram_disable (ram_disable),
  .phys_bank   (phys_bank),
  .ext_sel     (ext_sel),
  .base_strobe (base_strobe),
  .ext_strobe  (ext_strobe),
  .cfg_mode    (cfg_mode),
  .cfg_page    (cfg_page),
  .ext_hold    (ext_hold)
);

// File: tb/test_ram_bank_ctl.sv
module test_ram_bank_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        io_wr_en, cpu_mem, ras_req, ram_disable;
  logic [1:0]  phys_bank;
  logic        ext_sel;
  logic [2:0]  page;
  logic [13:0] phys_addr_lo;
  logic        base_strobe, ext_strobe;

  int errors = 0;
  int checks = 0;

  // reference model state
  int m_mode = 0, m_page = 0;
  bit m_hold = 0;
  bit e_ext, e_base_stb, e_ext_stb;
  int e_bank;

  always #4 clk = ~clk;

  ram_bank_ctl i_ram_bank_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_wr_en(io_wr_en), .cpu_mem(cpu_mem), .ras_req(ras_req),
    .ram_disable(ram_disable), .phys_bank(phys_bank), .ext_sel(ext_sel),
    .page(page), .phys_addr_lo(phys_addr_lo), .base_strobe(base_strobe),
    .ext_strobe(ext_strobe)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (addr=%h mode=%0d)",
               tag, what, act, exp, cpu_addr, m_mode);
    end
  endtask

  task automatic predict();
    int w;
    w = cpu_addr[15:14];
    if (!cpu_mem) begin
      e_ext = 0; e_bank = w;
    end else if (m_mode >= 4) begin
      e_ext  = (w == 1);
      e_bank = e_ext ? (m_mode % 4) : w;
    end else begin
      e_ext  = (m_mode == 2) || (w == 3 && (m_mode == 1 || m_mode == 3));
      e_bank = (m_mode == 3 && w == 1) ? 3 : w;
    end
    e_ext_stb  = ras_req && (m_hold || (cpu_mem && !ram_disable && e_ext));
    e_base_stb = ras_req && !m_hold && !e_ext_stb &&
                 (!cpu_mem || (!ram_disable && !e_ext));
  endtask

  task automatic cyc(input string tag);
    #3;
    predict();
    chk(tag, "phys_bank", phys_bank, e_bank);
    chk(tag, "ext_sel", ext_sel, e_ext);
    chk(tag == "R3" ? "R3" : "R9", "page", page, m_page);
    chk("R13", "phys_addr_lo", phys_addr_lo, cpu_addr[13:0]);
    chk(tag, "base_strobe", base_strobe, e_base_stb);
    chk(tag, "ext_strobe", ext_strobe, e_ext_stb);
    @(posedge clk);
    if (!rst_n) begin
      m_mode = 0; m_page = 0; m_hold = 0;
    end else begin
      if (io_wr_en && !cpu_addr[15] && cpu_wdata[7] && cpu_wdata[6]) begin
        m_mode = cpu_wdata % 8;
        m_page = (cpu_wdata / 8) % 8;
      end
      m_hold = e_ext_stb;
    end
    @(negedge clk);
  endtask

  task automatic mem(input logic [15:0] a, input bit cpu, input bit ras,
                     input bit dis, input string tag);
    cpu_addr = a; cpu_mem = cpu; ras_req = ras; ram_disable = dis;
    cyc(tag);
  endtask

  task automatic iowr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cpu_addr = a; cpu_wdata = d; io_wr_en = 1; cpu_mem = 0; ras_req = 0;
    ram_disable = 0;
    cyc(tag);
    io_wr_en = 0;
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 4; w++) begin
      mem(16'(w * 16384 + 16'h0123 + w * 16'h0311), 1, 1, 0, tag);
      mem(16'h0000, 0, 0, 0, tag);
      mem(16'(w * 16384 + 16'h2A5C), 0, 1, 0, "R10");
      mem(16'h0000, 0, 0, 0, "R10");
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cpu_addr = 0; cpu_wdata = 0; io_wr_en = 0;
    cpu_mem = 0; ras_req = 0; ram_disable = 0;
    @(negedge clk);
    mem(16'hC000, 1, 1, 0, "R3");
    mem(16'h4000, 1, 0, 0, "R3");
    rst_n = 1;
    sweep("R4");
    iowr(16'h7F00, 8'hC0 | (3 << 3) | 1, "R1");
    sweep("R5");
    iowr(16'h3F00, 8'hC2 | (5 << 3), "R2");
    sweep("R6");
    iowr(16'h7FFF, 8'hC3 | (7 << 3), "R2");
    sweep("R7");
    for (int m = 4; m < 8; m++) begin
      iowr(16'h7F00, 8'(8'hC0 | (((m * 3) % 8) << 3) | m), "R8");
      sweep("R8");
    end
    // ignored writes: wrong data pattern or A15 set
    iowr(16'h7F00, 8'h82, "R1");
    iowr(16'h7F00, 8'h42, "R1");
    iowr(16'h3F00, 8'h0A, "R1");
    iowr(16'hBF00, 8'hC2, "R1");
    iowr(16'hFF00, 8'hF0, "R1");
    sweep("R1");
    // immediate effect after write
    iowr(16'h7F00, 8'hF2, "R14");
    mem(16'h0123, 1, 1, 0, "R14");
    mem(16'h0000, 0, 0, 0, "R14");
    sweep("R9");
    // RAM-disable gating
    mem(16'h4000, 1, 1, 1, "R11");
    mem(16'h0000, 0, 0, 0, "R11");
    iowr(16'h7F00, 8'hC0, "R11");
    mem(16'h8000, 1, 1, 1, "R11");
    mem(16'h8000, 0, 1, 1, "R11");
    mem(16'h0000, 0, 0, 0, "R11");
    // held expansion strobe
    iowr(16'h7F00, 8'hC2, "R12");
    mem(16'h4000, 1, 1, 0, "R12");
    mem(16'h4000, 1, 1, 1, "R12");
    mem(16'h8000, 0, 1, 1, "R12");
    mem(16'hC000, 1, 1, 0, "R12");
    mem(16'hC000, 1, 0, 0, "R12");
    mem(16'h8000, 0, 1, 0, "R12");
    mem(16'h0000, 0, 0, 0, "R12");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule